// File: doc/BRIEF.md
# Two-Source Output Buffer Arbiter

This block sits between two byte-producing peripherals, a keyboard-side source and a pointing-device source, and the host-visible flags of a legacy input controller. Each source raises a "byte available" level while it holds data. The block records the two levels in a two-bit pending state and derives from it the buffer-full flags of the status byte and of the output-port byte, the two interrupt request levels, and a select that tells the data-port read path which source should supply the byte.

The keyboard source has strict priority. When both sources hold data, the keyboard's byte is presented and the pointing-device flags and interrupt stay low until the keyboard source drains. The controller's mode byte gates each interrupt: one enable bit per source, plus a keyboard-disable bit that also masks the keyboard interrupt. The mode byte acts on the outputs in the same cycle it changes. Bits of the status and output-port bytes that this block does not own pass straight through from their inputs.

The pending state is a four-state machine: EMPTY (nothing pending), KEY (keyboard only), AUX (pointing device only) and BOTH. On every clock edge the machine moves to the state named by the current pair of levels, so every state can reach every other in one step. The transitions are: FILL_KEY (keyboard level high, pointing-device level low) to KEY; FILL_AUX (pointing-device level high, keyboard level low) to AUX; FILL_BOTH (both high) to BOTH; DRAIN (both low) to EMPTY.

Top module: `kbc_obuf_arbiter`

## Requirements
- R1: The pending state is registered. It is EMPTY after reset, and one clock edge after the levels change it takes encoding {aux_avail, key_avail}, where bit 0 means keyboard pending and bit 1 means pointing device pending.
- R2: Status bit 0 and output-port bit 4 are 1 exactly when the pending state is not EMPTY.
- R3: Status bit 5 and output-port bit 5 are 1 only when the pending state is AUX (encoding 2'b10). In the BOTH state they are 0.
- R4: aux_irq is high exactly when the pending state is AUX and mode bit 1 is 1.
- R5: key_irq is high exactly when keyboard data is pending (state KEY or BOTH), mode bit 0 is 1 and mode bit 4 is 0.
- R6: rd_from_aux is 1 only in the AUX state. In EMPTY, KEY and BOTH it is 0, so the read comes from the keyboard source.
- R7: key_irq and aux_irq are never high together.
- R8: Status bits 1, 2, 3, 4, 6 and 7 equal the same bits of status_in. Output-port bits 0, 1, 2, 3, 6 and 7 equal the same bits of port_in.
- R9: A change of mode_byte changes key_irq and aux_irq without waiting for a clock edge. It leaves the pending state and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_avail | input | 1 | Keyboard source holds a byte |
| aux_avail | input | 1 | Pointing-device source holds a byte |
| mode_byte | input | 8 | Controller mode byte (bit 0 keyboard irq enable, bit 1 aux irq enable, bit 4 keyboard disable) |
| status_in | input | 8 | Status byte bits owned elsewhere |
| port_in | input | 8 | Output-port byte bits owned elsewhere |
| status_out | output | 8 | Status byte with buffer-full flags merged in |
| port_out | output | 8 | Output-port byte with buffer-full flags merged in |
| key_irq | output | 1 | Keyboard interrupt request level |
| aux_irq | output | 1 | Pointing-device interrupt request level |
| rd_from_aux | output | 1 | Data read takes its byte from the pointing-device source |

## Verification
The sweep covers all 256 mode bytes in each of the four pending states. It targets the BOTH state most of all. A design that let the pointing device win there would raise aux_irq, set bit 5 or steer the read to the wrong source. A design that tested "pointing device pending" rather than "pointing device alone" would fail the same checks. The keyboard-disable bit is checked with the enable bit both set and clear; a design that ignored it would raise key_irq while the interface is disabled. Separate checks change the levels just before a clock edge and the mode byte between edges. They would catch flags that follow the levels without a register, and interrupts that were registered rather than derived from the mode byte directly.

// File: rtl/kbc_arb_pkg.sv
package kbc_arb_pkg;

    // Pending-state encoding: bit 0 keyboard data, bit 1 pointing-device data
    typedef enum logic [1:0] {
        ARB_EMPTY = 2'b00,
        ARB_KEY   = 2'b01,
        ARB_AUX   = 2'b10,
        ARB_BOTH  = 2'b11
    } arb_state_t;

    localparam int BYTE_W        = 8;

    // mode byte fields
    localparam int MB_KEY_IRQ_EN = 0;
    localparam int MB_AUX_IRQ_EN = 1;
    localparam int MB_KEY_OFF    = 4;

    // status byte fields owned here
    localparam int SB_FULL       = 0;
    localparam int SB_AUX_FULL   = 5;

    // output-port byte fields owned here
    localparam int PB_FULL       = 4;
    localparam int PB_AUX_FULL   = 5;

endpackage

// File: rtl/kbc_pend_fsm.sv
module kbc_pend_fsm
    import kbc_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_lvl,
    input  logic       aux_lvl,
    output arb_state_t state_q
);

    arb_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: DRAIN, FILL_KEY, FILL_AUX, FILL_BOTH from any state
    always_comb begin
        unique case ({aux_lvl, key_lvl})
            2'b00:   state_d = ARB_EMPTY;
            2'b01:   state_d = ARB_KEY;
            2'b10:   state_d = ARB_AUX;
            2'b11:   state_d = ARB_BOTH;
            default: state_d = ARB_EMPTY;
        endcase
    end

endmodule

// File: rtl/kbc_flag_merge.sv
module kbc_flag_merge
    import kbc_arb_pkg::*;
#(
    parameter int W        = BYTE_W,
    parameter int FULL_BIT = 0,
    parameter int AUX_BIT  = 5
) (
    input  arb_state_t     state_q,
    input  logic [W-1:0]   byte_in,
    output logic [W-1:0]   byte_out
);

    logic any_pend;
    logic aux_alone;

    always_comb begin
        any_pend  = 1'b0;
        aux_alone = 1'b0;
        unique case (state_q)
            ARB_EMPTY: begin any_pend = 1'b0; aux_alone = 1'b0; end
            ARB_KEY:   begin any_pend = 1'b1; aux_alone = 1'b0; end
            ARB_AUX:   begin any_pend = 1'b1; aux_alone = 1'b1; end
            ARB_BOTH:  begin any_pend = 1'b1; aux_alone = 1'b0; end
            default:   begin any_pend = 1'b0; aux_alone = 1'b0; end
        endcase
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == FULL_BIT) begin : g_full
            assign byte_out[i] = any_pend;
        end else if (i == AUX_BIT) begin : g_aux
            assign byte_out[i] = aux_alone;
        end else begin : g_pass
            assign byte_out[i] = byte_in[i];
        end
    end

endmodule

// File: rtl/kbc_irq_gen.sv
module kbc_irq_gen
    import kbc_arb_pkg::*;
(
    input  arb_state_t        state_q,
    input  logic [BYTE_W-1:0] mode_byte,
    output logic              key_irq,
    output logic              aux_irq,
    output logic              rd_from_aux
);

    logic key_ok;
    logic aux_ok;

    assign key_ok = mode_byte[MB_KEY_IRQ_EN] & ~mode_byte[MB_KEY_OFF];
    assign aux_ok = mode_byte[MB_AUX_IRQ_EN];

    // output decode per state
    always_comb begin
        key_irq     = 1'b0;
        aux_irq     = 1'b0;
        rd_from_aux = 1'b0;
        unique case (state_q)
            ARB_EMPTY: ;
            ARB_KEY:   key_irq = key_ok;
            ARB_AUX: begin
                aux_irq     = aux_ok;
                rd_from_aux = 1'b1;
            end
            ARB_BOTH:  key_irq = key_ok;
            default: ;
        endcase
    end

endmodule

// File: rtl/kbc_obuf_arbiter.sv
module kbc_obuf_arbiter
    import kbc_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_avail,
    input  logic              aux_avail,
    input  logic [BYTE_W-1:0] mode_byte,
    input  logic [BYTE_W-1:0] status_in,
    input  logic [BYTE_W-1:0] port_in,
    output logic [BYTE_W-1:0] status_out,
    output logic [BYTE_W-1:0] port_out,
    output logic              key_irq,
    output logic              aux_irq,
    output logic              rd_from_aux
);

    arb_state_t pend_q;

    kbc_pend_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_lvl (key_avail),
        .aux_lvl (aux_avail),
        .state_q (pend_q)
    );

    kbc_flag_merge #(
        .W        (BYTE_W),
        .FULL_BIT (SB_FULL),
        .AUX_BIT  (SB_AUX_FULL)
    ) u_status (
        .state_q  (pend_q),
        .byte_in  (status_in),
        .byte_out (status_out)
    );

    kbc_flag_merge #(
        .W        (BYTE_W),
        .FULL_BIT (PB_FULL),
        .AUX_BIT  (PB_AUX_FULL)
    ) u_port (
        .state_q  (pend_q),
        .byte_in  (port_in),
        .byte_out (port_out)
    );

    kbc_irq_gen u_irq (
        .state_q     (pend_q),
        .mode_byte   (mode_byte),
        .key_irq     (key_irq),
        .aux_irq     (aux_irq),
        .rd_from_aux (rd_from_aux)
    );

endmodule

// File: rtl/kbc_obuf_arbiter_chk.sv
module kbc_obuf_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       key_avail,
    input logic       aux_avail,
    input logic [7:0] mode_byte,
    input logic [7:0] status_in,
    input logic [7:0] port_in,
    input logic [7:0] status_out,
    input logic [7:0] port_out,
    input logic       key_irq,
    input logic       aux_irq,
    input logic       rd_from_aux
);

    // R1 / R2: any level high makes the buffer look full one edge later
    p_full_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_avail || aux_avail) |=> (status_out[0] && port_out[4]));

    // R1: both levels low drains one edge later
    p_drain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_avail && !aux_avail) |=> (!status_out[0] && !port_out[4]));

    // R3: pointing device alone shows the aux-full flags
    p_aux_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_avail && !key_avail) |=> (status_out[5] && port_out[5]));

    // R6: keyboard priority on the read select
    p_key_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_avail |=> (!rd_from_aux && !status_out[5]));

    // R7: interrupts are exclusive
    p_irq_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(key_irq && aux_irq));

    // R5: keyboard interrupt needs enable, no disable, and a full buffer
    p_key_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        key_irq |-> (mode_byte[0] && !mode_byte[4] && status_out[0] && !rd_from_aux));

    // R4: aux interrupt only with enable and the aux-only read select
    p_aux_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        aux_irq |-> (mode_byte[1] && rd_from_aux));

endmodule

bind kbc_obuf_arbiter kbc_obuf_arbiter_chk chk_i (.*);

// File: tb/kbc_obuf_arbiter_tb_top.sv
module kbc_obuf_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       key_avail;
    logic       aux_avail;
    logic [7:0] mode_byte;
    logic [7:0] status_in;
    logic [7:0] port_in;
    logic [7:0] status_out;
    logic [7:0] port_out;
    logic       key_irq;
    logic       aux_irq;
    logic       rd_from_aux;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    kbc_obuf_arbiter dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_avail   (key_avail),
        .aux_avail   (aux_avail),
        .mode_byte   (mode_byte),
        .status_in   (status_in),
        .port_in     (port_in),
        .status_out  (status_out),
        .port_out    (port_out),
        .key_irq     (key_irq),
        .aux_irq     (aux_irq),
        .rd_from_aux (rd_from_aux)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status(input logic kp, input logic ap, input logic [7:0] si);
        logic any_p = kp | ap;
        logic alone = ap & ~kp;
        return (si & 8'hDE) | (8'(alone) << 5) | 8'(any_p);
    endfunction

    function automatic logic [7:0] exp_port(input logic kp, input logic ap, input logic [7:0] pi);
        logic any_p = kp | ap;
        logic alone = ap & ~kp;
        return (pi & 8'hCF) | (8'(alone) << 5) | (8'(any_p) << 4);
    endfunction

    task automatic check_all(input logic kp, input logic ap);
        logic alone = ap & ~kp;
        chk("R2/R3/R8 status", status_out, exp_status(kp, ap, status_in));
        chk("R2/R3/R8 port", port_out, exp_port(kp, ap, port_in));
        chk("R5 key_irq", 8'(key_irq), 8'(kp & mode_byte[0] & ~mode_byte[4]));
        chk("R4 aux_irq", 8'(aux_irq), 8'(alone & mode_byte[1]));
        chk("R6 rd_from_aux", 8'(rd_from_aux), 8'(alone));
        chk("R7 exclusive", 8'(key_irq & aux_irq), 8'h00);
    endtask

    initial begin
        rst_n = 1'b0; key_avail = 1'b1; aux_avail = 1'b1;
        mode_byte = 8'h03; status_in = 8'h18; port_in = 8'h03;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state is EMPTY even with both levels high
        check_all(1'b0, 1'b0);
        key_avail = 1'b0; aux_avail = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);

        // exhaustive sweep: four pending states x all mode bytes
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 256; m++) begin
                key_avail = s[0];
                aux_avail = s[1];
                mode_byte = 8'(m);
                status_in = 8'(m) ^ 8'hA5;
                port_in   = ~8'(m);
                @(posedge clk); @(negedge clk);
                check_all(s[0], s[1]);
            end
        end

        // R1: level change is not visible before the next edge
        key_avail = 1'b0; aux_avail = 1'b0; mode_byte = 8'h03;
        @(posedge clk); @(negedge clk);
        key_avail = 1'b1; aux_avail = 1'b1;
        #2;
        chk("R1 before edge", status_out & 8'h21, 8'h00);
        @(posedge clk); @(negedge clk);
        chk("R1 after edge BOTH", status_out & 8'h21, 8'h01);
        aux_avail = 1'b1; key_avail = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 BOTH->AUX", status_out & 8'h21, 8'h21);

        // R9: mode change between edges in AUX state
        mode_byte = 8'h00;
        #2;
        chk("R9 aux_irq off", 8'(aux_irq), 8'h00);
        chk("R9 flags steady", status_out & 8'h21, 8'h21);
        mode_byte = 8'h02;
        #2;
        chk("R9 aux_irq on", 8'(aux_irq), 8'h01);
        @(negedge clk);
        key_avail = 1'b1; aux_avail = 1'b0; mode_byte = 8'h11;
        @(posedge clk); @(negedge clk);
        chk("R9 key masked by disable", 8'(key_irq), 8'h00);
        mode_byte = 8'h01;
        #2;
        chk("R9 key_irq on", 8'(key_irq), 8'h01);
        chk("R9 rd select steady", 8'(rd_from_aux), 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule